// File: doc/BRIEF.md
# Eight-Pin Masked GPIO Port with Interrupt Detection

This block is an eight-pin general purpose I/O port on a simple 32-bit memory-mapped register bus (select, enable, write, address, write data, read data). Each pin is an input or an output according to a direction register. Software reaches the pin data through an address window where word-address bits act as a per-bit mask. A single store can therefore change chosen output pins without a read-modify-write. A load returns only the chosen pins.

Each pin has its own interrupt detector. It can work on a level or on an edge, with selectable polarity, and in edge mode it can react to both edges. Edge events are latched until software clears them. Level events follow the pin directly. Per-pin enables form a masked status, and one combined interrupt output reports whether any masked bit is set. Pin inputs pass through a two-flop synchroniser before any detection.

Top module: `gpio8_masked`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are zero and `irq` is low.
- R2: A write at byte offset 0x000–0x3FC updates only the output bits whose mask bit is 1. The mask is `paddr[9:2]`: bit n of the mask is `paddr[n+2]`. All other output bits keep their value.
- R3: A read in the data window returns, in the low 8 bits, the pin data ANDed with the mask `paddr[9:2]`. Unmasked positions read 0. For an output pin the pin data is the driven value. For an input pin it is the synchronised input.
- R4: The register at 0x400 sets direction. Bit n = 1 makes pin n an output (`pin_oe[n]`=1). Bit n = 0 makes it an input. It reads back its value.
- R5: When bit n of the sense register (0x404) is 1, the pin is level sensitive. Its raw status bit (read at 0x414) is 1 while the synchronised input equals bit n of the polarity register (0x40C): 1 means high, 0 means low. This bit is not latched.
- R6: When bit n of the sense register is 0 and bit n of the both-edges register (0x408) is 0, the pin is edge sensitive. Polarity 1 latches raw status on a rising edge. Polarity 0 latches it on a falling edge. The opposite edge has no effect.
- R7: When bit n of the both-edges register is 1 and the pin is edge sensitive, either edge latches raw status, and the polarity bit is ignored.
- R8: Masked status (0x418) equals raw status AND the enable register (0x410). `irq` is high exactly when masked status is nonzero.
- R9: Writing 1 to bit n of the clear register (0x41C) clears the latched edge status of pin n. Writing 0 leaves it unchanged. The clear register reads 0.
- R10: If a new edge is detected in the same cycle as a clear of the same pin, the status stays set.
- R11: An input change first shows in level status after the second rising clock edge that follows it. It first shows in latched edge status after the third rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase; a write takes effect on a rising edge with psel, penable and pwrite high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data (low 8 bits used) |
| prdata | output | 32 | Read data, combinational while psel is high, upper bits zero |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output data |
| pin_oe | output | 8 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted output or direction register shows up on `pin_out`/`pin_oe` immediately after the faulty write. A masked write sweep over all 256 masks therefore exposes a wrong mask bit within one access. A wrong edge latch or a wrong polarity decode shows in raw status, in masked status and on `irq` three edges after the input change. The bench reads these after every input step of a long pattern sequence, under two configurations with opposite polarities. Clear and coincident-edge errors show on the next status read after the clear.

// File: rtl/gpio8_masked.sv
module gpio8_masked #(
  parameter int W  = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  localparam int MSB = W + 1;

  logic [W-1:0] out_q, dir_q, sense_q, both_q, pol_q, ien_q, edge_q;
  logic [W-1:0] s1_q, s2_q, prev_q;
  logic [W-1:0] rise, fall, hit, clr, raw, masked, mask, pin_val, wd;
  logic         wr, in_data, in_regs;
  logic [2:0]   rsel;

  assign wr      = psel & penable & pwrite;
  assign in_data = paddr[AW-1:MSB+1] == '0;
  assign in_regs = (paddr[AW-1:MSB+1] == 1) && (paddr[MSB:5] == '0);
  assign rsel    = paddr[4:2];
  assign mask    = paddr[MSB:2];
  assign wd      = pwdata[W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; prev_q <= '0;
    end else begin
      s1_q <= pin_in; s2_q <= s1_q; prev_q <= s2_q;
    end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;
  assign hit  = ~sense_q & ((both_q & (rise | fall)) |
                            (~both_q & pol_q & rise) |
                            (~both_q & ~pol_q & fall));
  assign clr  = (wr && in_regs && rsel == 3'd7) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_q <= '0; dir_q <= '0; sense_q <= '0; both_q <= '0;
      pol_q <= '0; ien_q <= '0; edge_q <= '0;
    end else begin
      edge_q <= (edge_q & ~clr) | hit;
      if (wr && in_data) out_q <= (out_q & ~mask) | (wd & mask);
      if (wr && in_regs)
        case (rsel)
          3'd0: dir_q   <= wd;
          3'd1: sense_q <= wd;
          3'd2: both_q  <= wd;
          3'd3: pol_q   <= wd;
          3'd4: ien_q   <= wd;
          default: ;
        endcase
    end

  assign raw     = (sense_q & ~(s2_q ^ pol_q)) | (~sense_q & edge_q);
  assign masked  = raw & ien_q;
  assign irq     = |masked;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign pin_val = (dir_q & out_q) | (~dir_q & s2_q);

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (in_data) prdata[W-1:0] = pin_val & mask;
      else if (in_regs)
        case (rsel)
          3'd0: prdata[W-1:0] = dir_q;
          3'd1: prdata[W-1:0] = sense_q;
          3'd2: prdata[W-1:0] = both_q;
          3'd3: prdata[W-1:0] = pol_q;
          3'd4: prdata[W-1:0] = ien_q;
          3'd5: prdata[W-1:0] = raw;
          3'd6: prdata[W-1:0] = masked;
          default: ;
        endcase
    end
  end

  assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_regs && rsel == 3'd0) |=> (pin_oe == $past(pwdata[W-1:0])));

  assert_mask_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && in_data) |=>
      (((pin_out ^ $past(pin_out)) & ~$past(paddr[MSB:2])) == '0));

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pwrite) |=> $stable(pin_out));

  assert_latch_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & ~$past(edge_q) & ~$past(s2_q ^ prev_q)) == '0));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/gpio8_masked_test.sv
module gpio8_masked_test;
  logic clk = 0, rst_n = 0, psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [7:0]  pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int checks = 0, errors = 0;
  logic [7:0] m_out, m_latch, c_sense, c_both, c_pol, c_ien, cur_in;

  gpio8_masked uut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = {24'h0, d};
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    #1 d = prdata;
    psel = 0;
  endtask

  task automatic settle(); repeat (4) @(posedge clk); @(negedge clk); endtask

  function automatic logic [7:0] model_hit(input logic [7:0] o, input logic [7:0] n);
    logic [7:0] r, f;
    r = n & ~o; f = ~n & o;
    return ~c_sense & ((c_both & (r | f)) | (~c_both & c_pol & r) | (~c_both & ~c_pol & f));
  endfunction

  function automatic logic [7:0] model_raw(input logic [7:0] n);
    return (c_sense & ~(n ^ c_pol)) | (~c_sense & m_latch);
  endfunction

  task automatic irq_run(input logic [7:0] pol);
    logic [31:0] d;
    logic [7:0] nxt, exp_raw;
    c_sense = 8'h03; c_both = 8'hF0; c_pol = pol; c_ien = 8'hAF;
    wr(12'h404, c_sense); wr(12'h408, c_both); wr(12'h40C, c_pol); wr(12'h410, c_ien);
    wr(12'h41C, 8'hFF); m_latch = 0;
    for (int s = 0; s < 96; s++) begin
      nxt = 8'((s * 37) ^ (s >> 2) ^ 8'h3C);
      pin_in = nxt; settle();
      m_latch = m_latch | model_hit(cur_in, nxt); cur_in = nxt;
      exp_raw = model_raw(cur_in);
      rd(12'h414, d); check("R5/R6/R7 raw status", d, {24'h0, exp_raw});
      rd(12'h418, d); check("R8 masked status", d, {24'h0, exp_raw & c_ien});
      check("R8 irq", {31'h0, irq}, {31'h0, |(exp_raw & c_ien)});
      if (s % 4 == 3) begin
        nxt = 8'(s * 29);
        wr(12'h41C, nxt); m_latch = m_latch & ~nxt;
        rd(12'h414, d); check("R9 clear", d, {24'h0, model_raw(cur_in)});
        rd(12'h41C, d); check("R9 clear reads zero", d, 0);
      end
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] v, e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", {24'h0, pin_oe}, 0);
    check("R1 pin_out", {24'h0, pin_out}, 0);
    check("R1 irq", {31'h0, irq}, 0);
    for (int r = 0; r < 8; r++) begin
      rd(12'h400 + 12'(r * 4), d); check("R1 register zero", d, 0);
    end
    // R4 direction
    wr(12'h400, 8'hFF); check("R4 pin_oe", {24'h0, pin_oe}, 32'hFF);
    rd(12'h400, d); check("R4 readback", d, 32'hFF);
    // R2 masked write sweep
    m_out = 0;
    for (int m = 0; m < 256; m++) begin
      v = 8'((m * 73) ^ 8'h5A);
      wr({2'b00, 8'(m), 2'b00}, v);
      m_out = (m_out & ~8'(m)) | (v & 8'(m));
      check("R2 masked write", {24'h0, pin_out}, {24'h0, m_out});
    end
    // R3 masked read sweep, mixed direction
    wr(12'h400, 8'hA5); wr(12'h3FC, 8'h3C); m_out = 8'h3C;
    check("R4 pin_oe mixed", {24'h0, pin_oe}, 32'hA5);
    pin_in = 8'h96; settle();
    for (int m = 0; m < 256; m++) begin
      e = ((8'hA5 & m_out) | (8'h5A & 8'h96)) & 8'(m);
      rd({2'b00, 8'(m), 2'b00}, d); check("R3 masked read", d, {24'h0, e});
    end
    wr(12'h400, 8'h00);
    // R5 R6 R7 R8 R9 over two polarity configs
    cur_in = pin_in;
    irq_run(8'h25);
    irq_run(8'hDA);
    // R11 latency: pin0 level high, pin2 rising
    c_sense = 8'h01; c_both = 8'h00; c_pol = 8'h05;
    wr(12'h404, c_sense); wr(12'h408, c_both); wr(12'h40C, c_pol);
    pin_in = 8'h00; settle(); wr(12'h41C, 8'hFF);
    @(negedge clk); pin_in = 8'h05;
    @(posedge clk); rd(12'h414, d); check("R11 after first edge", d & 32'h5, 0);
    @(posedge clk); rd(12'h414, d); check("R11 level after second edge", d & 32'h5, 32'h1);
    @(posedge clk); rd(12'h414, d); check("R11 edge after third edge", d & 32'h5, 32'h5);
    // R6 opposite edge ignored
    wr(12'h41C, 8'h04); pin_in = 8'h00; settle();
    rd(12'h414, d); check("R6 falling ignored on rising pin", d & 32'h4, 0);
    // R10 edge coincident with clear
    @(negedge clk); pin_in = 8'h04;
    @(posedge clk); @(posedge clk);
    @(negedge clk); psel = 1; pwrite = 1; penable = 1; paddr = 12'h41C; pwdata = 32'h04;
    @(negedge clk); psel = 0; pwrite = 0; penable = 0;
    rd(12'h414, d); check("R10 edge wins over clear", d & 32'h4, 32'h4);
    wr(12'h41C, 8'h04);
    rd(12'h414, d); check("R9 clear without edge", d & 32'h4, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule